// File: doc/BRIEF.md
# Quadrature Encoder Position and Speed Capture Timer

This block measures the position and speed of a servo motor fitted with a two-phase incremental encoder. It has two channels that are wired to each other.

The encoder channel synchronizes the A and B phases and decodes every edge of either phase. This gives a 16-bit up/down position count at four times the encoder line rate.

The reference channel is a counter that advances on every clock. It has two compare registers:

- The position-cycle compare sets the control period. The counter returns to zero after it matches this value.
- The speed-cycle compare marks a shorter interval inside that period. It does not disturb the counter.

The two channels feed each other:

- Each compare match latches the position count into its own capture register. Firmware then reads the count at fixed control instants.
- Each decoded encoder step latches the reference counter into a pulse-width register. The older value moves into a buffer register at the same time. The difference between the two registers is the time between consecutive encoder edges, which is the input for low-speed estimation.

Sticky flags record the three events. Firmware clears a flag by writing a one to its bit.

Top module: `qenc_capture_timer`

## Requirements
- R1: Each input passes through a two-flop synchronizer. A change on an encoder input sampled at clock edge k appears in `pos_count` at edge k+2. With the state index 00→0, 10→1, 11→2, 01→3 (written as {A,B}), a move to the next index modulo 4 counts up by one. Each of the four edges in a full A-leading cycle therefore counts.
- R2: A move to the previous index modulo 4 (B leading) counts down by one.
- R3: If both phases change in the same synchronized cycle, the move is illegal. It leaves `pos_count` unchanged and triggers no pulse-width capture.
- R4: `pos_count` wraps modulo 2^16. One step down from 0x0000 gives 0xFFFF, and one step up from 0xFFFF gives 0x0000.
- R5: `ref_count` increments by one on every clock. In the cycle after it equals the position-cycle compare value, it reads 0.
- R6: When `ref_count` equals the speed-cycle compare value, the counter is not cleared and `pos_count` is captured into `spd_cap`.
- R7: When `ref_count` equals the position-cycle compare value, `pos_count` is captured into `pos_cap`.
- R8: On each counted encoder step, `ref_count` is captured into `pw_cap` and the previous `pw_cap` moves into `pw_buf` on the same edge.
- R9: When a capture trigger and a counter update fall on the same edge, the captured value is the counter value from before that edge's update.
- R10: `flags` bit 0 is set by a speed-cycle match, bit 1 by a position-cycle match, and bit 2 by a pulse-width capture. Each bit stays set until a write with `wr_sel`=2 carries a 1 in that bit of `wr_data`. Bits written with 0 are unaffected. If a set and a clear arrive on the same edge, the set wins.
- R11: `wr_sel`=0 writes the position-cycle compare value and `wr_sel`=1 writes the speed-cycle compare value. Both take effect on the next edge.
- R12: While `rst` is high, every count, capture register and flag reads 0, and both compare registers load 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 position compare, 1 speed compare, 2 flag clear |
| wr_data | input | 16 | Write data |
| pos_count | output | 16 | Encoder position count |
| ref_count | output | 16 | Reference counter |
| spd_cap | output | 16 | Position count captured at the speed-cycle match |
| pos_cap | output | 16 | Position count captured at the position-cycle match |
| pw_cap | output | 16 | Reference count captured at the latest encoder step |
| pw_buf | output | 16 | Previous contents of `pw_cap` |
| flags | output | 3 | Sticky event flags |

## Verification
The bench steps through all sixteen pairs of previous and next phase state and computes the expected position change from the state indices. If the design swapped the direction rule, it would count backwards. If it counted a two-phase jump, it would show a count and a spurious pulse-width capture.

The bench also reads the reference counter one cycle before each step and compares that value with `pw_cap` and `pw_buf`. A design with an off-by-one capture point or without the buffering shift would fail that comparison.

An encoder step is lined up with a speed-cycle match on the same edge. A design that captured the post-update position would report a value one count off.

The reference counter sequence is followed across clears, and the count is walked across zero in both directions. These checks catch a counter that clears at the wrong value, clears on the speed match, or saturates instead of wrapping.

// File: rtl/qct_pkg.sv
package qct_pkg;
  typedef enum logic [1:0] {
    WR_POS_CMP  = 2'd0,
    WR_SPD_CMP  = 2'd1,
    WR_FLAG_CLR = 2'd2
  } wr_sel_e;

  localparam int FLAG_SPD  = 0;
  localparam int FLAG_POS  = 1;
  localparam int FLAG_PW   = 2;
  localparam int NUM_FLAGS = 3;
endpackage

// File: rtl/qct_quad_decoder.sv
module qct_quad_decoder #(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enc_a,
  input  logic             enc_b,
  output logic             step,
  output logic             step_up,
  output logic [CNT_W-1:0] count
);
  logic [SYNC_STAGES-1:0] a_sync;
  logic [SYNC_STAGES-1:0] b_sync;
  logic a_prev, b_prev;
  logic a_now, b_now, a_chg, b_chg;

  // synchronizer chain, length set by parameter
  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) begin
            a_sync[0] <= 1'b0;
            b_sync[0] <= 1'b0;
          end else begin
            a_sync[0] <= enc_a;
            b_sync[0] <= enc_b;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) begin
            a_sync[gi] <= 1'b0;
            b_sync[gi] <= 1'b0;
          end else begin
            a_sync[gi] <= a_sync[gi-1];
            b_sync[gi] <= b_sync[gi-1];
          end
        end
      end
    end
  endgenerate

  assign a_now = a_sync[SYNC_STAGES-1];
  assign b_now = b_sync[SYNC_STAGES-1];
  assign a_chg = a_now ^ a_prev;
  assign b_chg = b_now ^ b_prev;

  // exactly one phase moved: legal step; both moved: dropped
  assign step    = a_chg ^ b_chg;
  assign step_up = a_chg ? (a_now ^ b_now) : ~(a_now ^ b_now);

  always_ff @(posedge clk) begin
    if (rst) begin
      a_prev <= 1'b0;
      b_prev <= 1'b0;
      count  <= '0;
    end else begin
      a_prev <= a_now;
      b_prev <= b_now;
      if (step) begin
        count <= step_up ? count + 1'b1 : count - 1'b1;
      end
    end
  end
endmodule

// File: rtl/qct_ref_timer.sv
module qct_ref_timer
  import qct_pkg::*;
#(
  parameter int               CNT_W   = 16,
  parameter logic [CNT_W-1:0] CMP_RST = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] ref_count,
  output logic             pos_hit,
  output logic             spd_hit
);
  logic [CNT_W-1:0] pos_cmp_q;
  logic [CNT_W-1:0] spd_cmp_q;

  assign pos_hit = (ref_count == pos_cmp_q);
  assign spd_hit = (ref_count == spd_cmp_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_cmp_q <= CMP_RST;
      spd_cmp_q <= CMP_RST;
    end else if (wr_en) begin
      if (wr_sel == 2'(WR_POS_CMP)) pos_cmp_q <= wr_data;
      if (wr_sel == 2'(WR_SPD_CMP)) spd_cmp_q <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          ref_count <= '0;
    else if (pos_hit) ref_count <= '0;
    else              ref_count <= ref_count + 1'b1;
  end
endmodule

// File: rtl/qct_capture_bank.sv
module qct_capture_bank
  import qct_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CNT_W-1:0]     pos_count,
  input  logic [CNT_W-1:0]     ref_count,
  input  logic                 spd_hit,
  input  logic                 pos_hit,
  input  logic                 step,
  input  logic                 clr_en,
  input  logic [NUM_FLAGS-1:0] clr_mask,
  output logic [CNT_W-1:0]     spd_cap,
  output logic [CNT_W-1:0]     pos_cap,
  output logic [CNT_W-1:0]     pw_cap,
  output logic [CNT_W-1:0]     pw_buf,
  output logic [NUM_FLAGS-1:0] flags
);
  logic [NUM_FLAGS-1:0] set_vec;
  logic [NUM_FLAGS-1:0] clr_vec;

  always_comb begin
    set_vec           = '0;
    set_vec[FLAG_SPD] = spd_hit;
    set_vec[FLAG_POS] = pos_hit;
    set_vec[FLAG_PW]  = step;
  end
  assign clr_vec = clr_en ? clr_mask : '0;

  // captures take the counters' pre-edge values
  always_ff @(posedge clk) begin
    if (rst) begin
      spd_cap <= '0;
      pos_cap <= '0;
      pw_cap  <= '0;
      pw_buf  <= '0;
    end else begin
      if (spd_hit) spd_cap <= pos_count;
      if (pos_hit) pos_cap <= pos_count;
      if (step) begin
        pw_buf <= pw_cap;
        pw_cap <= ref_count;
      end
    end
  end

  genvar fi;
  generate
    for (fi = 0; fi < NUM_FLAGS; fi++) begin : g_flag
      always_ff @(posedge clk) begin
        if (rst) flags[fi] <= 1'b0;
        else     flags[fi] <= set_vec[fi] | (flags[fi] & ~clr_vec[fi]);
      end
    end
  endgenerate
endmodule

// File: rtl/qenc_capture_timer.sv
module qenc_capture_timer
  import qct_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 enc_a,
  input  logic                 enc_b,
  input  logic                 wr_en,
  input  logic [1:0]           wr_sel,
  input  logic [CNT_W-1:0]     wr_data,
  output logic [CNT_W-1:0]     pos_count,
  output logic [CNT_W-1:0]     ref_count,
  output logic [CNT_W-1:0]     spd_cap,
  output logic [CNT_W-1:0]     pos_cap,
  output logic [CNT_W-1:0]     pw_cap,
  output logic [CNT_W-1:0]     pw_buf,
  output logic [NUM_FLAGS-1:0] flags
);
  logic step, step_up, pos_hit, spd_hit, clr_en;

  assign clr_en = wr_en && (wr_sel == 2'(WR_FLAG_CLR));

  qct_quad_decoder #(.SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W)) u_dec (
    .clk(clk), .rst(rst), .enc_a(enc_a), .enc_b(enc_b),
    .step(step), .step_up(step_up), .count(pos_count)
  );

  qct_ref_timer #(.CNT_W(CNT_W)) u_ref (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ref_count(ref_count), .pos_hit(pos_hit), .spd_hit(spd_hit)
  );

  qct_capture_bank #(.CNT_W(CNT_W)) u_cap (
    .clk(clk), .rst(rst), .pos_count(pos_count), .ref_count(ref_count),
    .spd_hit(spd_hit), .pos_hit(pos_hit), .step(step),
    .clr_en(clr_en), .clr_mask(wr_data[NUM_FLAGS-1:0]),
    .spd_cap(spd_cap), .pos_cap(pos_cap), .pw_cap(pw_cap), .pw_buf(pw_buf),
    .flags(flags)
  );
endmodule

// File: rtl/qct_checker.sv
module qct_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             step,
  input logic             step_up,
  input logic             pos_hit,
  input logic             spd_hit,
  input logic             wr_en,
  input logic [1:0]       wr_sel,
  input logic [CNT_W-1:0] wr_data,
  input logic [CNT_W-1:0] pos_count,
  input logic [CNT_W-1:0] ref_count,
  input logic [CNT_W-1:0] spd_cap,
  input logic [CNT_W-1:0] pos_cap,
  input logic [CNT_W-1:0] pw_cap,
  input logic [CNT_W-1:0] pw_buf,
  input logic [2:0]       flags
);
  a_r1_count_up: assert property (@(posedge clk) disable iff (rst)
    step && step_up |=> pos_count == CNT_W'($past(pos_count) + 1'b1));

  a_r2_count_down: assert property (@(posedge clk) disable iff (rst)
    step && !step_up |=> pos_count == CNT_W'($past(pos_count) - 1'b1));

  a_r3_hold_without_step: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(pos_count));

  a_r5_advance: assert property (@(posedge clk) disable iff (rst)
    !pos_hit |=> ref_count == CNT_W'($past(ref_count) + 1'b1));

  a_r5_clear: assert property (@(posedge clk) disable iff (rst)
    pos_hit |=> ref_count == '0);

  a_r6_speed_capture: assert property (@(posedge clk) disable iff (rst)
    spd_hit |=> spd_cap == $past(pos_count));

  a_r7_position_capture: assert property (@(posedge clk) disable iff (rst)
    pos_hit |=> pos_cap == $past(pos_count));

  a_r8_pulse_capture: assert property (@(posedge clk) disable iff (rst)
    step |=> pw_cap == $past(ref_count) && pw_buf == $past(pw_cap));

  a_r8_pulse_hold: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(pw_cap) && $stable(pw_buf));

  genvar fi;
  generate
    for (fi = 0; fi < 3; fi++) begin : g_flag_chk
      a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
        flags[fi] && !(wr_en && wr_sel == 2'd2 && wr_data[fi]) |=> flags[fi]);
    end
  endgenerate
endmodule

bind qenc_capture_timer qct_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .step(step), .step_up(step_up),
  .pos_hit(pos_hit), .spd_hit(spd_hit),
  .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .pos_count(pos_count), .ref_count(ref_count),
  .spd_cap(spd_cap), .pos_cap(pos_cap), .pw_cap(pw_cap), .pw_buf(pw_buf),
  .flags(flags)
);

// File: tb/qenc_capture_timer_tb.sv
module qenc_capture_timer_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enc_a = 1'b0, enc_b = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] pos_count, ref_count, spd_cap, pos_cap, pw_cap, pw_buf;
  logic [2:0]  flags;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qenc_capture_timer u_dut (
    .clk(clk), .rst(rst), .enc_a(enc_a), .enc_b(enc_b),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .pos_count(pos_count), .ref_count(ref_count), .spd_cap(spd_cap),
    .pos_cap(pos_cap), .pw_cap(pw_cap), .pw_buf(pw_buf), .flags(flags)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [1:0] sel, input logic [15:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_enc(input logic [1:0] ab);
    @(negedge clk);
    enc_a = ab[1]; enc_b = ab[0];
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    #1;
  endtask

  function automatic int gidx(input logic [1:0] ab);
    case (ab)
      2'b00:   return 0;
      2'b10:   return 1;
      2'b11:   return 2;
      default: return 3;
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] p0, rref, pwprev, exp_ref;
    int guard;

    repeat (4) @(posedge clk);
    #1;
    // R12 reset state
    check("R12 pos_count", pos_count, 0);
    check("R12 ref_count", ref_count, 0);
    check("R12 captures", {spd_cap, pos_cap, pw_cap, pw_buf}, 0);
    check("R12 flags", flags, 0);
    @(negedge clk); rst = 1'b0;

    // R11 compare writes: position cycle 10, speed cycle 4
    write_reg(2'd0, 16'd10);
    write_reg(2'd1, 16'd4);

    // R5/R6 reference counter sequence: clears after 10, not at 4
    @(negedge clk);
    exp_ref = ref_count;
    for (int i = 0; i < 40; i++) begin
      exp_ref = (exp_ref == 16'd10) ? 16'd0 : exp_ref + 16'd1;
      @(negedge clk);
      check("R5 ref sequence", ref_count, exp_ref);
    end

    // R2/R4 wrap below zero and back
    set_enc(2'b01); settle();
    check("R4 wrap down", pos_count, 16'hFFFF);
    set_enc(2'b00); settle();
    check("R4 wrap up", pos_count, 16'h0000);

    // R1 four steps of an A-leading cycle
    set_enc(2'b10); settle();
    set_enc(2'b11); settle();
    set_enc(2'b01); settle();
    set_enc(2'b00); settle();
    check("R1 4x count", pos_count, 16'd4);
    set_enc(2'b10); settle();
    check("R1 one more", pos_count, 16'd5);

    // R6/R7 captures of the position after a full reference period
    repeat (12) @(posedge clk);
    #1;
    check("R6 speed capture", spd_cap, 16'd5);
    check("R7 position capture", pos_cap, 16'd5);
    check("R10 match flags", flags[1:0], 2'b11);
    check("R10 pulse flag set", flags[2], 1'b1);

    // R10 clear only bit 2
    write_reg(2'd2, 16'h0004);
    #1;
    check("R10 pulse flag cleared", flags[2], 1'b0);
    check("R10 speed flag kept", flags[0], 1'b1);

    // R1/R2/R3/R8 sweep of all previous/next state pairs
    for (int p = 0; p < 4; p++) begin
      for (int n = 0; n < 4; n++) begin
        int d, dexp;
        set_enc(2'(p)); settle();
        p0 = pos_count;
        set_enc(2'(n));
        @(posedge clk); @(posedge clk); #1;
        rref = ref_count; pwprev = pw_cap;
        @(posedge clk); #1;
        d = (gidx(2'(n)) - gidx(2'(p)) + 4) % 4;
        dexp = (d == 1) ? 1 : (d == 3) ? -1 : 0;
        check(d == 2 ? "R3 illegal no count" : (d == 3 ? "R2 down step" : "R1 up step"),
              pos_count, 16'(int'(p0) + dexp));
        if (dexp != 0) begin
          check("R8 pw_cap", pw_cap, rref);
          check("R8 pw_buf", pw_buf, pwprev);
        end else begin
          check("R3 no pulse capture", pw_cap, pwprev);
        end
      end
    end

    // R9 step and speed match on the same edge
    write_reg(2'd1, 16'd7);
    set_enc(2'b00); settle();
    p0 = pos_count;
    guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (ref_count != 16'd5 && guard < 50);
    enc_a = 1'b1; enc_b = 1'b0;
    @(posedge clk); @(posedge clk); @(posedge clk); #1;
    check("R9 speed capture pre-update", spd_cap, p0);
    check("R9 count updated", pos_count, 16'(p0 + 16'd1));
    check("R9 pw_cap equals match value", pw_cap, 16'd7);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule